// File: doc/BRIEF.md
# Stream-to-Memory Write DMA Engine

This engine takes words arriving on a valid/ready stream input and stores them in memory through a burst-capable memory-mapped write master. Software steers the traffic with descriptors. It writes a destination address, a length in words and a control word into staging registers. Writing the control word with its commit bit set moves the staged descriptor into a descriptor queue. The engine executes the queued descriptors one at a time, in submission order. For each descriptor it accepts exactly the number of stream words it needs, buffers them in a data FIFO, and writes them out in bursts to consecutive word addresses.

A source-address register exists so that software can use the same four-register descriptor layout in both copy directions. In this direction its content is discarded. Each descriptor may ask for an interrupt when its last word has been written. A sticky pending bit records that event and is gated onto the interrupt line by a global enable. A soft reset command flushes all queued work and buffered data over a fixed number of cycles. A status register reports when that flush is in progress.

Top module: `dma_s2m_top`

## Requirements
- R1: Register map on `reg_addr`: 0 is status, 1 is control, 4 is the source address, 5 is the destination address, 6 is the length and 7 is the descriptor control word. A descriptor is queued only when word 7 is written with bit 31 set. A write to word 7 with bit 31 clear queues nothing and leaves the engine idle.
- R2: The source-address register has no effect. Beat k of a descriptor is written at the destination address plus k times DATA_W/8.
- R3: A length above MAX_WORDS is executed as MAX_WORDS. A zero length completes without any memory write.
- R4: `s_ready` is high only while a descriptor is executing, the data FIFO is not full and that descriptor still needs stream words. No word is accepted beyond the total length of the committed descriptors.
- R5: Each burst carries `mem_burst` = min(MAX_BURST, words left in the descriptor). While `mem_wait` stalls a beat, `mem_addr` holds the burst start, and `mem_burst` and `mem_data` stay stable.
- R6: Descriptors execute strictly in commit order. Memory data equals the accepted stream words in order. Nothing is written that no descriptor asked for.
- R7: When the last word of a descriptor whose control bit 0 is set has been written, status bit 2 becomes set. `irq` equals status bit 2 AND control bit 0. Writing 1 to status bit 2 clears it; a set in the same cycle wins over the clear.
- R8: Writing control bit 1 starts a soft reset. Status bit 1 then reads 1 for exactly RST_CYCLES cycles. The reset discards queued descriptors and buffered words, clears the pending bit and the global enable, and keeps `s_ready` and `mem_wr` low.
- R9: Status bits: 0 busy (a descriptor executing or queued), 3 data FIFO empty, 4 data FIFO full, 5 descriptor queue full, 6 descriptor queue empty. When idle the status reads 0x48.
- R10: A commit while the descriptor queue is full is dropped, and no memory write ever results from it.
- R11: While memory stalls, the engine keeps accepting stream words until exactly DATA_DEPTH words are buffered. It then reports the data FIFO full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted when high with `s_valid` |
| s_data | input | DATA_W | Stream word |
| mem_wr | output | 1 | Memory write request, one beat per cycle |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_burst | output | $clog2(MAX_BURST+1) | Beats in the current burst |
| mem_data | output | DATA_W | Write data of the current beat |
| mem_wait | input | 1 | Memory stalls the current beat |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with an 8-word data FIFO, a 4-entry descriptor queue, bursts of up to 4 beats, a 20-word length cap and a 3-cycle soft reset. These small values let short runs reach the full data FIFO, the full descriptor queue and the length clamp. They also produce tail bursts shorter than the cap. Random stalls on both the stream and memory sides exercise held bursts, and a timed stream burst checks that a soft reset drops partially buffered words.

// File: rtl/dma_s2m_pkg.sv
package dma_s2m_pkg;

  // register word indices
  localparam logic [2:0] REG_STATUS = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_SRC    = 3'd4;
  localparam logic [2:0] REG_DST    = 3'd5;
  localparam logic [2:0] REG_LEN    = 3'd6;
  localparam logic [2:0] REG_DESC   = 3'd7;

  // bit positions
  localparam int DESC_GO_BIT  = 31;
  localparam int DESC_IRQ_BIT = 0;
  localparam int CTRL_GIE_BIT = 0;
  localparam int CTRL_RST_BIT = 1;
  localparam int ST_IRQ_BIT   = 2;

  // beats of the next burst: the cap, or what is left if fewer
  function automatic int unsigned burst_beats(int unsigned left, int unsigned cap);
    return (left < cap) ? left : cap;
  endfunction

  // requested length limited to the per-descriptor maximum
  function automatic int unsigned clamp_words(int unsigned len, int unsigned max_words);
    return (len > max_words) ? max_words : len;
  endfunction

  // byte step between two bursts
  function automatic int unsigned burst_bytes(int unsigned beats, int unsigned word_bytes);
    return beats * word_bytes;
  endfunction

endpackage

// File: rtl/dma_s2m_fifo.sv
module dma_s2m_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dma_s2m_writer.sv
module dma_s2m_writer
  import dma_s2m_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  parameter int CW        = 5,
  localparam int BW       = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic [CW-1:0]     fifo_count,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BW-1:0]     mem_burst,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_wait,
  output logic              active,
  output logic              done
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic              act_q, bon_q;
  logic [ADDR_W-1:0] nxt_addr, addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [BW-1:0]     beats_q, burst_q, blen;
  logic              start, beat_ok;

  assign blen    = BW'(burst_beats(32'(left_q), MAX_BURST));
  assign start   = act_q && !bon_q && (left_q != '0) && (32'(fifo_count) >= 32'(blen));
  assign beat_ok = bon_q && !mem_wait;
  assign done    = act_q && ((beat_ok && left_q == LEN_W'(1)) || (left_q == '0 && !bon_q));

  assign mem_wr    = bon_q;
  assign mem_addr  = addr_q;
  assign mem_burst = burst_q;
  assign mem_data  = fifo_head;
  assign fifo_pop  = beat_ok;
  assign active    = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      bon_q    <= 1'b0;
      nxt_addr <= '0;
      addr_q   <= '0;
      left_q   <= '0;
      beats_q  <= '0;
      burst_q  <= '0;
    end else if (abort) begin
      act_q  <= 1'b0;
      bon_q  <= 1'b0;
      left_q <= '0;
    end else begin
      if (start) begin
        bon_q    <= 1'b1;
        addr_q   <= nxt_addr;
        burst_q  <= blen;
        beats_q  <= blen;
        nxt_addr <= nxt_addr + ADDR_W'(burst_bytes(32'(blen), WORD_BYTES));
      end
      if (beat_ok) begin
        left_q  <= left_q - LEN_W'(1);
        beats_q <= beats_q - BW'(1);
        if (beats_q == BW'(1)) bon_q <= 1'b0;
      end
      if (done) act_q <= 1'b0;
      if (load) begin
        act_q    <= 1'b1;
        nxt_addr <= load_addr;
        left_q   <= load_len;
        bon_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_s2m_top.sv
module dma_s2m_top
  import dma_s2m_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_DEPTH = 16,
  parameter int DESC_DEPTH = 8,
  parameter int MAX_BURST  = 8,
  parameter int MAX_WORDS  = 1024,
  parameter int RST_CYCLES = 4,
  localparam int BW        = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BW-1:0]     mem_burst,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_wait,
  output logic              irq
);
  localparam int DCW = $clog2(DATA_DEPTH + 1);
  localparam int QCW = $clog2(DESC_DEPTH + 1);
  localparam int QW  = 1 + ADDR_W + LEN_W;
  localparam int RCW = $clog2(RST_CYCLES + 1);

  // named internal events, also observed by the checker
  logic resetting, irq_pend, gie, done_evt, wr_active, d_full, d_empty;
  logic q_full, q_empty, load, s_acc, go_cmd, q_push, busy;

  logic [RCW-1:0]    rst_cnt;
  logic [ADDR_W-1:0] stage_dst;
  logic [LEN_W-1:0]  stage_len, len_cl, in_left;
  logic              cur_irq;
  logic [QW-1:0]     q_din, q_dout;
  logic [QCW-1:0]    q_cnt;
  logic [DCW-1:0]    d_cnt;
  logic [DATA_W-1:0] d_head;
  logic              d_pop;

  assign resetting = (rst_cnt != '0);
  assign len_cl    = LEN_W'(clamp_words(32'(stage_len), MAX_WORDS));
  assign go_cmd    = reg_wr && (reg_addr == REG_DESC) && reg_wdata[DESC_GO_BIT] && !resetting;
  assign q_full    = (q_cnt == QCW'(DESC_DEPTH));
  assign q_empty   = (q_cnt == '0);
  assign q_push    = go_cmd && !q_full;
  assign q_din     = {reg_wdata[DESC_IRQ_BIT], stage_dst, len_cl};
  assign load      = (!wr_active || done_evt) && !q_empty && !resetting;
  assign d_full    = (d_cnt == DCW'(DATA_DEPTH));
  assign d_empty   = (d_cnt == '0);
  assign s_ready   = wr_active && !resetting && !d_full && (in_left != '0);
  assign s_acc     = s_valid && s_ready;
  assign busy      = wr_active || !q_empty;
  assign irq       = irq_pend && gie;

  // descriptor staging (source address register is accepted and dropped)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_dst <= '0;
      stage_len <= '0;
    end else if (reg_wr) begin
      if (reg_addr == REG_DST) stage_dst <= ADDR_W'(reg_wdata);
      if (reg_addr == REG_LEN) stage_len <= LEN_W'(reg_wdata);
    end
  end

  dma_s2m_fifo #(.W(QW), .DEPTH(DESC_DEPTH)) u_desc_q (
    .clk(clk), .rst_n(rst_n), .flush(resetting),
    .push(q_push), .din(q_din), .pop(load), .dout(q_dout), .count(q_cnt)
  );

  dma_s2m_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk(clk), .rst_n(rst_n), .flush(resetting),
    .push(s_acc), .din(s_data), .pop(d_pop), .dout(d_head), .count(d_cnt)
  );

  dma_s2m_writer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .MAX_BURST(MAX_BURST), .CW(DCW)
  ) u_writer (
    .clk(clk), .rst_n(rst_n), .abort(resetting),
    .load(load), .load_addr(q_dout[LEN_W +: ADDR_W]), .load_len(q_dout[LEN_W-1:0]),
    .fifo_count(d_cnt), .fifo_head(d_head), .fifo_pop(d_pop),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_data(mem_data),
    .mem_wait(mem_wait), .active(wr_active), .done(done_evt)
  );

  // stream words still owed to the executing descriptor, and its irq request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_left <= '0;
      cur_irq <= 1'b0;
    end else if (resetting) begin
      in_left <= '0;
      cur_irq <= 1'b0;
    end else if (load) begin
      in_left <= q_dout[LEN_W-1:0];
      cur_irq <= q_dout[QW-1];
    end else if (s_acc) begin
      in_left <= in_left - LEN_W'(1);
    end
  end

  // control and status state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt  <= '0;
      gie      <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (resetting)
        rst_cnt <= rst_cnt - RCW'(1);
      else if (reg_wr && reg_addr == REG_CTRL && reg_wdata[CTRL_RST_BIT])
        rst_cnt <= RCW'(RST_CYCLES);

      if (resetting)
        gie <= 1'b0;
      else if (reg_wr && reg_addr == REG_CTRL)
        gie <= reg_wdata[CTRL_GIE_BIT];

      if (resetting)
        irq_pend <= 1'b0;
      else if (done_evt && cur_irq)
        irq_pend <= 1'b1;
      else if (reg_wr && reg_addr == REG_STATUS && reg_wdata[ST_IRQ_BIT])
        irq_pend <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_STATUS: reg_rdata = {25'b0, q_empty, q_full, d_full, d_empty, irq_pend, resetting, busy};
      REG_CTRL:   reg_rdata = {31'b0, gie};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_s2m_chk.sv
module dma_s2m_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 8,
  localparam int BW       = $clog2(MAX_BURST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              mem_wr,
  input logic              mem_wait,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BW-1:0]     mem_burst,
  input logic [DATA_W-1:0] mem_data,
  input logic              irq_pend,
  input logic              done_evt,
  input logic              resetting,
  input logic              wr_active
);
  // stalled beat keeps address, count and data
  p_hold_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && mem_wait |=> mem_wr && $stable(mem_addr) && $stable(mem_burst) && $stable(mem_data));

  // burst count within the configured cap
  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_burst != '0) && (32'(mem_burst) <= MAX_BURST));

  // stream is only taken while a descriptor executes
  p_ready_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> wr_active);

  // soft reset keeps both data ports quiet
  p_quiet_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resetting && $past(resetting) |-> !mem_wr && !(s_valid && s_ready));

  // the pending bit is raised only by a descriptor completion
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(done_evt));
endmodule

bind dma_s2m_top dma_s2m_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .mem_wr(mem_wr), .mem_wait(mem_wait), .mem_addr(mem_addr), .mem_burst(mem_burst),
  .mem_data(mem_data), .irq_pend(irq_pend), .done_evt(done_evt),
  .resetting(resetting), .wr_active(wr_active)
);

// File: tb/tb_dma_s2m_top.sv
module tb_dma_s2m_top;
  localparam int CLK_P = 10;
  localparam int DW = 32, AW = 32, LW = 16;
  localparam int DDEP = 8, QDEP = 4, MB = 4, MAXW = 20, RSTC = 3;
  localparam int BWD = $clog2(MB + 1);
  localparam int WB = DW / 8;
  localparam logic [31:0] ST_IDLE = 32'h48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic s_valid = 1'b0, s_ready;
  logic [DW-1:0] s_data = 32'h100;
  logic mem_wr, mem_wait = 1'b0, irq;
  logic [AW-1:0] mem_addr;
  logic [BWD-1:0] mem_burst;
  logic [DW-1:0] mem_data;

  dma_s2m_top #(
    .DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .DATA_DEPTH(DDEP), .DESC_DEPTH(QDEP),
    .MAX_BURST(MB), .MAX_WORDS(MAXW), .RST_CYCLES(RSTC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_data(mem_data),
    .mem_wait(mem_wait), .irq(irq)
  );

  always #(CLK_P / 2) clk = ~clk;

  // reference model state
  int unsigned e_addr[$];
  int unsigned e_rem[$];
  bit          e_irq[$];
  logic [31:0] got[$];
  int room = 0;
  bit m_sticky = 0, m_gie = 0, irq_free = 0;
  int bidx = 0;
  logic [31:0] bl_cur = '0, a0 = '0;
  int n_cmp = 0, n_bad = 0, n_acc = 0, cyc = 0;
  bit s_en = 0, s_rand = 0, w_rand = 0, w_force = 0, acc = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // stream source and memory stall generator, driven after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (acc) s_data = s_data + 32'd1;
    s_valid = s_en && (!s_rand || lfsr[0]);
    mem_wait = w_force || (w_rand && lfsr[3]);
  end

  // per-clock comparison against the model, sampled mid-cycle
  always @(negedge clk) begin
    bit set_irq;
    set_irq = 0;
    if (rst_n) begin
      if (!irq_free) chk(32'(irq), 32'(m_sticky && m_gie), "R7 irq line");
      acc = s_valid && s_ready;
      if (acc) begin
        if (room <= 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R4 word accepted with no room: actual %0h expected none", s_data);
        end else room--;
        got.push_back(s_data);
        n_acc++;
      end
      if (mem_wr) begin
        if (e_addr.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6 unrequested write: actual %0h expected none", mem_addr);
        end else begin
          if (bidx == 0) begin
            bl_cur = 32'(mem_burst);
            a0 = mem_addr;
            chk(32'(mem_burst), (e_rem[0] < MB) ? e_rem[0] : MB, "R5 burst length");
          end else begin
            chk(mem_addr, a0, "R5 burst address held");
            chk(32'(mem_burst), bl_cur, "R5 burst count held");
          end
          if (!mem_wait) begin
            chk(mem_addr + 32'(bidx * WB), e_addr[0], "R2 beat address");
            if (got.size() == 0) begin
              n_cmp++; n_bad++;
              $display("FAIL R6 beat before data: actual %0h expected none", mem_data);
            end else begin
              chk(mem_data, got[0], "R6 data order");
              void'(got.pop_front());
            end
            if (e_irq[0]) set_irq = 1;
            void'(e_addr.pop_front());
            void'(e_rem.pop_front());
            void'(e_irq.pop_front());
            bidx++;
            if (32'(bidx) == bl_cur) bidx = 0;
          end
        end
      end
      if (reg_wr && reg_addr == 3'd0 && reg_wdata[2]) m_sticky = 0;
      if (reg_wr && reg_addr == 3'd1) begin
        m_gie = reg_wdata[0];
        if (reg_wdata[1]) begin
          m_gie = 0; m_sticky = 0; set_irq = 0;
          e_addr.delete(); e_rem.delete(); e_irq.delete(); got.delete();
          room = 0; bidx = 0;
        end
      end
      if (set_irq) m_sticky = 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic submit(input logic [31:0] src, input logic [31:0] dst, input int len,
                        input bit irqen, input bit go, input bit keep);
    int n;
    wr(3'd4, src);
    wr(3'd5, dst);
    wr(3'd6, 32'(len));
    wr(3'd7, {go, 30'b0, irqen});
    if (go && keep) begin
      n = (len > MAXW) ? MAXW : len;
      for (int i = 0; i < n; i++) begin
        e_addr.push_back(dst + 32'(i * WB));
        e_rem.push_back(32'(n - i));
        e_irq.push_back(irqen && (i == n - 1));
      end
      room += n;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && e_addr.size() != 0; i++) @(posedge clk);
    chk(32'(e_addr.size()), 0, "R6 all expected beats written");
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int cnt, a_before;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(32'(s_ready), 0, "R4 ready low after reset");
    chk(32'(mem_wr), 0, "R6 no write after reset");
    rd(3'd0, v); chk(v, ST_IDLE, "R9 reset status");
    rd(3'd1, v); chk(v, 0, "R7 enable clear after reset");

    // R1: control write without commit bit queues nothing
    submit(32'h0, 32'h4000, 5, 1, 0, 0);
    repeat (10) @(posedge clk);
    rd(3'd0, v); chk(v, ST_IDLE, "R1 no commit stays idle");

    // R2 R7: basic transfer, source register ignored, per-descriptor irq
    wr(3'd1, 32'h1);
    @(negedge clk); s_en = 1;
    submit(32'hDEAD0000, 32'h1000, 10, 1, 1, 1);
    drain();
    rd(3'd0, v); chk(v & 32'h7, 32'h4, "R7 pending set, not busy");
    chk(32'(irq), 1, "R7 irq asserted");
    wr(3'd0, 32'h4);
    @(negedge clk); chk(32'(irq), 0, "R7 write-one clear");

    // R5 R6: several descriptors under random stalls
    @(negedge clk); s_rand = 1; w_rand = 1;
    submit(32'h0, 32'h2000, 7, 0, 1, 1);
    submit(32'h0, 32'h3000, 1, 0, 1, 1);
    submit(32'h0, 32'h3800, 5, 1, 1, 1);
    drain();
    rd(3'd0, v); chk(v & 32'h4, 32'h4, "R7 irq only after last descriptor");
    wr(3'd0, 32'h4);

    // R3: length clamp
    submit(32'h0, 32'h5000, 30, 0, 1, 1);
    drain();
    rd(3'd0, v); chk(v, ST_IDLE, "R3 clamped descriptor done");

    // R3: zero length completes with irq and no writes
    irq_free = 1;
    submit(32'h0, 32'h9000, 0, 1, 1, 1);
    repeat (10) @(posedge clk);
    rd(3'd0, v); chk(v & 32'h7, 32'h4, "R3 zero length completes");
    m_sticky = 1;
    @(negedge clk); irq_free = 0;
    wr(3'd0, 32'h4);

    // R11: memory stalled, FIFO absorbs DATA_DEPTH words
    @(negedge clk); s_rand = 0; w_rand = 0; w_force = 1;
    a_before = n_acc;
    submit(32'h0, 32'h6000, 16, 0, 1, 1);
    repeat (20) @(posedge clk);
    chk(32'(n_acc - a_before), DDEP, "R11 words absorbed during stall");
    rd(3'd0, v); chk(v & 32'h19, 32'h11, "R11 FIFO full and busy");
    chk(32'(s_ready), 0, "R4 ready low on full FIFO");
    @(negedge clk); w_force = 0;
    drain();

    // R10: descriptor queue full drops a commit
    @(negedge clk); s_en = 0;
    submit(32'h0, 32'h7000, 2, 0, 1, 1);
    for (int k = 0; k < QDEP; k++) submit(32'h0, 32'h7100 + 32'(k * 32'h100), 1, 0, 1, 1);
    rd(3'd0, v); chk(v & 32'h61, 32'h21, "R9 queue full status");
    submit(32'h0, 32'h8800, 3, 1, 1, 0);
    rd(3'd0, v); chk(v & 32'h21, 32'h21, "R10 still full after drop");
    @(negedge clk); s_en = 1;
    drain();
    rd(3'd0, v); chk(v, ST_IDLE, "R10 dropped commit never ran");

    // R8: soft reset discards partial data
    @(negedge clk); s_en = 0;
    submit(32'h0, 32'hA000, 8, 1, 1, 1);
    @(negedge clk); s_en = 1;
    repeat (3) @(negedge clk);
    s_en = 0;
    repeat (3) @(posedge clk);
    wr(3'd1, 32'h3);
    reg_addr = 3'd0;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (reg_rdata[1]) cnt++;
    end
    chk(32'(cnt), RSTC, "R8 resetting duration");
    rd(3'd0, v); chk(v, ST_IDLE, "R8 status after reset");
    rd(3'd1, v); chk(v, 0, "R8 enable cleared");
    @(negedge clk); s_en = 1;
    submit(32'h0, 32'hB000, 4, 0, 1, 1);
    drain();
    rd(3'd0, v); chk(v, ST_IDLE, "R8 engine usable after reset");

    summary();
    $finish;
  end
endmodule